// File: doc/BRIEF.md
# Privilege-Filtered Performance Event Counter

This block holds a small bank of general event counters and one cycle counter. Each general counter selects one line of an event pulse vector and adds one for every pulse it sees. The cycle counter adds one for every clock cycle, or, in divided mode, one for every 64 cycles it accumulates. A per-counter type register holds a set of privilege filter bits. Every increment is first tested against the current exception level (0 to 3) and the secure-state flag. If the filter rejects it, the increment is discarded before anything else sees it, and that includes the divider's remainder.

Software reaches all state through one register port, with a write path and a read path. That state is the counter values, the type registers, a mode register, a per-counter enable register and a shared overflow status register that is cleared by writing ones. The read path returns data one cycle after the request.

Register map, using a 5-bit address where bits [4:3] select a region and bits [2:0] select an index:
- Region 0 holds the counter values. Index i (i < 4) is general counter i, index 4 is the low word of the cycle counter and index 5 is its high word.
- Region 1 holds the type registers. Index i (i < 4) belongs to general counter i and index 4 belongs to the cycle counter.
- Region 2 holds three registers. Index 0 is the mode register: bit 0 is the global enable and bit 1 is the divide-by-64 select. Index 1 is the enable register: bit i enables general counter i and bit 4 enables the cycle counter. Index 2 is the overflow status, using the same bit positions as the enable register.

Type register layout:
- Bits [7:0] hold the event selector.
- Filter bits: bit 8 is privileged (P), bit 9 is user (U), bit 10 is non-secure kernel (NSK), bit 11 is non-secure user (NSU), bit 12 is non-secure hypervisor (NSH) and bit 13 is monitor (M).

Top module: `priv_event_counter`

## Requirements
- R1: At exception level 0, a secure increment is dropped when U is 1. A non-secure increment is dropped when U differs from NSU.
- R2: At exception level 1, a secure increment is dropped when P is 1. A non-secure increment is dropped when P differs from NSK.
- R3: At exception level 2, an increment is dropped whenever NSH is 0, whatever the secure flag is.
- R4: At exception level 3, an increment is dropped when P differs from M, whatever the secure flag is.
- R5: A general counter adds one in each cycle in which its selected event line `evt_in[sel]` is high. A selector value of 8 or more never counts.
- R6: A counter advances only when mode bit 0 is set and its own enable bit is set.
- R7: General counters are 32 bits wide and the cycle counter is 64 bits wide. An increment that wraps a counter from all ones to zero sets its overflow bit: bit i for general counter i, bit 4 for the cycle counter.
- R8: Writing the overflow register clears each bit written as 1 and leaves each bit written as 0 unchanged. A wrap in the same cycle as a clear of that bit leaves the bit set.
- R9: With mode bit 1 clear, the cycle counter adds one per allowed cycle. With mode bit 1 set, it adds one for each 64 allowed cycles. Cycles that are filtered or disabled do not add to the remainder.
- R10: Reading a general type register returns the stored filter bits [13:8] and selector [7:0], with zeros above. A write to the cycle counter's type register stores only the filter bits, and a read of that register returns event number 0x11 in bits [7:0].
- R11: Writing a counter-value address loads that value. A load takes priority over an increment in the same cycle.
- R12: After reset, all counters, filters, selectors, mode, enable and overflow bits are zero.
- R13: `rd_data` shows the addressed register one cycle after a cycle with `rd_en` high. Bits of the overflow and enable registers above bit 4 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 8 | Event pulse vector, one increment per high bit per cycle |
| el | input | 2 | Current exception level |
| secure | input | 1 | Current secure-state flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Registered read data |

## Verification
Two functions can fall in the same cycle: a counter can wrap and set its overflow bit in the very cycle software writes a one to clear that bit. The bench loads a general counter with all ones, then in a single clock drives both the event pulse and the clearing write. It requires the overflow bit to read back as set, and then checks that a later clearing write does empty it. The other same-cycle pairing, a counter load against an increment, is provoked in the same way and judged by requiring the loaded value to win.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 5;
  localparam int SEL_W    = 8;
  localparam int FILT_W   = 6;
  localparam int FILT_LSB = SEL_W;

  localparam logic [1:0] RGN_CNT  = 2'd0;
  localparam logic [1:0] RGN_TYPE = 2'd1;
  localparam logic [1:0] RGN_CTL  = 2'd2;

  localparam logic [2:0] CTL_MODE = 3'd0;
  localparam logic [2:0] CTL_EN   = 3'd1;
  localparam logic [2:0] CTL_OVF  = 3'd2;

  typedef struct packed {
    logic m;
    logic nsh;
    logic nsu;
    logic nsk;
    logic u;
    logic p;
  } filt_t;
endpackage

// File: rtl/pfc_filter.sv
module pfc_filter
  import pfc_pkg::*;
(
  input  filt_t      filt,
  input  logic [1:0] el,
  input  logic       secure,
  output logic       allow
);
  always_comb begin
    case (el)
      2'd0:    allow = secure ? !filt.u : (filt.u == filt.nsu);
      2'd1:    allow = secure ? !filt.p : (filt.p == filt.nsk);
      2'd2:    allow = filt.nsh;
      default: allow = (filt.p == filt.m);
    endcase
  end
endmodule

// File: rtl/pfc_event_counter.sv
module pfc_event_counter
  import pfc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   sel,
  input  filt_t              filt,
  input  logic [1:0]         el,
  input  logic               secure,
  input  logic               run,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   cnt,
  output logic               wrap
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic allow;
  logic hit;
  logic inc;

  pfc_filter u_filter (
    .filt   (filt),
    .el     (el),
    .secure (secure),
    .allow  (allow)
  );

  always_comb begin
    if (sel < SEL_W'(NUM_EVT)) hit = evt[sel[IDX_W-1:0]];
    else                       hit = 1'b0;
  end

  assign inc  = run & allow & hit;
  assign wrap = inc & !load & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pfc_cycle_counter.sv
module pfc_cycle_counter
  import pfc_pkg::*;
#(
  parameter int CYC_W   = 64,
  parameter int DIV_LOG = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  filt_t            filt,
  input  logic [1:0]       el,
  input  logic             secure,
  input  logic             run,
  input  logic             div_en,
  input  logic             load_lo,
  input  logic             load_hi,
  input  logic [REG_W-1:0] load_val,
  output logic [CYC_W-1:0] cnt,
  output logic             wrap
);
  localparam int HI_W = CYC_W - REG_W;

  logic               allow;
  logic               tick;
  logic               step;
  logic               any_load;
  logic [DIV_LOG-1:0] rem;

  pfc_filter u_filter (
    .filt   (filt),
    .el     (el),
    .secure (secure),
    .allow  (allow)
  );

  assign tick     = run & allow;
  assign step     = tick & (!div_en | (&rem));
  assign any_load = load_lo | load_hi;
  assign wrap     = step & !any_load & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)                rem <= '0;
    else if (tick & div_en) rem <= rem + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      if (load_lo) cnt[REG_W-1:0] <= load_val;
      if (load_hi) cnt[CYC_W-1:REG_W] <= load_val[HI_W-1:0];
      if (!any_load && step) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/priv_event_counter.sv
module priv_event_counter
  import pfc_pkg::*;
#(
  parameter int         NUM_CNT   = 4,
  parameter int         CNT_W     = 32,
  parameter int         CYC_W     = 64,
  parameter int         NUM_EVT   = 8,
  parameter int         DIV_LOG   = 6,
  parameter logic [7:0] CYCLE_EVT = 8'h11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [1:0]         el,
  input  logic               secure,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data
);
  localparam int NB = NUM_CNT + 1;

  logic [1:0] wr_rgn, rd_rgn;
  logic [2:0] wr_idx, rd_idx;

  logic [NUM_CNT-1:0] cnt_load, type_wr;
  logic cyc_lo_ld, cyc_hi_ld, cyc_type_wr, mode_wr, en_wr, ovf_wr;

  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
  filt_t [NUM_CNT:0]             filt_q;
  logic                          glob_en_q, div_q;
  logic [NB-1:0]                 en_q, ovf_q;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [CYC_W-1:0]              cyc_q;
  logic [NB-1:0]                 wrap_v, run_v, clr_v;
  logic [REG_W-1:0]              rd_nxt;

  assign wr_rgn = wr_addr[4:3];
  assign wr_idx = wr_addr[2:0];
  assign rd_rgn = rd_addr[4:3];
  assign rd_idx = rd_addr[2:0];

  // write decode
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      cnt_load[i] = wr_en && (wr_rgn == RGN_CNT)  && (wr_idx == 3'(i));
      type_wr[i]  = wr_en && (wr_rgn == RGN_TYPE) && (wr_idx == 3'(i));
    end
    cyc_lo_ld   = wr_en && (wr_rgn == RGN_CNT)  && (wr_idx == 3'(NUM_CNT));
    cyc_hi_ld   = wr_en && (wr_rgn == RGN_CNT)  && (wr_idx == 3'(NUM_CNT + 1));
    cyc_type_wr = wr_en && (wr_rgn == RGN_TYPE) && (wr_idx == 3'(NUM_CNT));
    mode_wr     = wr_en && (wr_rgn == RGN_CTL)  && (wr_idx == CTL_MODE);
    en_wr       = wr_en && (wr_rgn == RGN_CTL)  && (wr_idx == CTL_EN);
    ovf_wr      = wr_en && (wr_rgn == RGN_CTL)  && (wr_idx == CTL_OVF);
  end

  // type registers: filter always stored, selector only on a change
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      filt_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (type_wr[i]) begin
          filt_q[i] <= filt_t'(wr_data[FILT_LSB +: FILT_W]);
          if (wr_data[SEL_W-1:0] != sel_q[i]) sel_q[i] <= wr_data[SEL_W-1:0];
        end
      end
      if (cyc_type_wr) filt_q[NUM_CNT] <= filt_t'(wr_data[FILT_LSB +: FILT_W]);
    end
  end

  // mode and enable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en_q <= 1'b0;
      div_q     <= 1'b0;
      en_q      <= '0;
    end else begin
      if (mode_wr) begin
        glob_en_q <= wr_data[0];
        div_q     <= wr_data[1];
      end
      if (en_wr) en_q <= wr_data[NB-1:0];
    end
  end

  // overflow status: a new wrap outranks a same-cycle clear
  assign clr_v = ovf_wr ? wr_data[NB-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= '0;
    else     ovf_q <= (ovf_q & ~clr_v) | wrap_v;
  end

  assign run_v = en_q & {NB{glob_en_q}};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    pfc_event_counter #(
      .CNT_W   (CNT_W),
      .NUM_EVT (NUM_EVT)
    ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .sel      (sel_q[g]),
      .filt     (filt_q[g]),
      .el       (el),
      .secure   (secure),
      .run      (run_v[g]),
      .evt      (evt_in),
      .load     (cnt_load[g]),
      .load_val (wr_data[CNT_W-1:0]),
      .cnt      (cnt_q[g]),
      .wrap     (wrap_v[g])
    );
  end

  pfc_cycle_counter #(
    .CYC_W   (CYC_W),
    .DIV_LOG (DIV_LOG)
  ) u_cyc (
    .clk      (clk),
    .rst      (rst),
    .filt     (filt_q[NUM_CNT]),
    .el       (el),
    .secure   (secure),
    .run      (run_v[NUM_CNT]),
    .div_en   (div_q),
    .load_lo  (cyc_lo_ld),
    .load_hi  (cyc_hi_ld),
    .load_val (wr_data),
    .cnt      (cyc_q),
    .wrap     (wrap_v[NUM_CNT])
  );

  // read mux
  always_comb begin
    rd_nxt = '0;
    case (rd_rgn)
      RGN_CNT: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (rd_idx == 3'(i)) rd_nxt = REG_W'(cnt_q[i]);
        if (rd_idx == 3'(NUM_CNT))     rd_nxt = cyc_q[REG_W-1:0];
        if (rd_idx == 3'(NUM_CNT + 1)) rd_nxt = REG_W'(cyc_q[CYC_W-1:REG_W]);
      end
      RGN_TYPE: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (rd_idx == 3'(i)) rd_nxt = REG_W'({filt_q[i], sel_q[i]});
        if (rd_idx == 3'(NUM_CNT)) rd_nxt = REG_W'({filt_q[NUM_CNT], CYCLE_EVT});
      end
      RGN_CTL: begin
        if (rd_idx == CTL_MODE) rd_nxt = REG_W'({div_q, glob_en_q});
        if (rd_idx == CTL_EN)   rd_nxt = REG_W'(en_q);
        if (rd_idx == CTL_OVF)  rd_nxt = REG_W'(ovf_q);
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
  import pfc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int CYC_W   = 64
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [REG_W-1:0]              wr_data,
  input logic                          rd_en,
  input logic [ADDR_W-1:0]             rd_addr,
  input logic [REG_W-1:0]              rd_data,
  input logic [1:0]                    el,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic [CYC_W-1:0]              cyc_q,
  input logic [NUM_CNT:0]              ovf_q,
  input logic                          glob_en_q,
  input logic [NUM_CNT:0][FILT_W-1:0]  filt_q
);
  localparam int NB = NUM_CNT + 1;
  localparam logic [ADDR_W-1:0] OVF_ADDR = {RGN_CTL, CTL_OVF};

  logic [NB-1:0] clr_mask;
  assign clr_mask = (wr_en && wr_addr == OVF_ADDR) ? wr_data[NB-1:0] : '0;

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(ovf_q) & ~ovf_q) & ~$past(clr_mask)) == '0));

  // R6
  glob_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(glob_en_q) && !$past(wr_en)) |-> (cnt_q == $past(cnt_q) && cyc_q == $past(cyc_q)));

  // R9
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> (cyc_q == $past(cyc_q) || cyc_q == CYC_W'($past(cyc_q) + 1'b1)));

  // R13
  rd_pad_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && rd_addr == OVF_ADDR) |-> (rd_data[REG_W-1:NB] == '0));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    // R3
    el2_block_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(el) == 2'd2 && !$past(filt_q[g][4]) && !$past(wr_en)) |-> (cnt_q[g] == $past(cnt_q[g])));

    // R5
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en) |-> (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == CNT_W'($past(cnt_q[g]) + 1'b1)));
  end
endmodule

bind priv_event_counter pfc_checker #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W),
  .CYC_W   (CYC_W)
) u_pfc_checker (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .el        (el),
  .cnt_q     (cnt_q),
  .cyc_q     (cyc_q),
  .ovf_q     (ovf_q),
  .glob_en_q (glob_en_q),
  .filt_q    (filt_q)
);

// File: tb/priv_event_counter_bench.sv
module priv_event_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_in = '0;
  logic [1:0]  el = 2'd0;
  logic        secure = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [4:0] A_CYC_LO = 5'd4, A_CYC_HI = 5'd5, A_TYPE0 = 5'd8,
                         A_TYPE_CYC = 5'd12, A_MODE = 5'd16, A_EN = 5'd17, A_OVF = 5'd18;

  always #2 clk = ~clk;

  priv_event_counter u_priv_event_counter (
    .clk(clk), .rst(rst), .evt_in(evt_in), .el(el), .secure(secure),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    evt_in = v;
    @(posedge clk); #1;
    evt_in = '0;
  endtask

  // filter bits: [0]=P [1]=U [2]=NSK [3]=NSU [4]=NSH [5]=M
  function automatic bit ref_allow(input logic [5:0] f, input int lvl, input bit s);
    case (lvl)
      0:       return s ? !f[1] : (f[1] == f[3]);
      1:       return s ? !f[0] : (f[0] == f[2]);
      2:       return f[4];
      default: return f[0] == f[5];
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int total;
    int c0, c2;
    do_reset();

    // R12 reset state
    for (int a = 0; a < 6; a++) begin rd(5'(a), d); chk("R12 counter", d, 0); end
    rd(A_MODE, d); chk("R12 mode", d, 0);
    rd(A_EN, d);   chk("R12 enable", d, 0);
    rd(A_OVF, d);  chk("R12 overflow", d, 0);
    rd(A_TYPE0, d); chk("R12 type", d, 0);

    // R1 R2 R3 R4 exhaustive filter sweep on counter 0 (selector 0)
    wr(A_MODE, 32'h1);
    wr(A_EN, 32'h1);
    total = 0;
    for (int f = 0; f < 64; f++) begin
      for (int lv = 0; lv < 4; lv++) begin
        for (int s = 0; s < 2; s++) begin
          wr(A_TYPE0, {18'd0, 6'(f), 8'h00});
          el = 2'(lv); secure = s[0];
          pulse(8'h01);
          if (ref_allow(6'(f), lv, s[0])) total++;
          rd(5'd0, d);
          case (lv)
            0: chk("R1 el0 filter", d, 32'(total));
            1: chk("R2 el1 filter", d, 32'(total));
            2: chk("R3 el2 filter", d, 32'(total));
            default: chk("R4 el3 filter", d, 32'(total));
          endcase
        end
      end
    end

    // R5 R6 selection, per-counter enable, out-of-range selector
    do_reset();
    el = 2'd3; secure = 1'b0;
    wr(A_TYPE0 + 5'd0, 32'h2);
    wr(A_TYPE0 + 5'd1, 32'h5);
    wr(A_TYPE0 + 5'd2, 32'h7);
    wr(A_TYPE0 + 5'd3, 32'h9);
    wr(A_MODE, 32'h1);
    wr(A_EN, 32'hD);
    c0 = 0; c2 = 0;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] v;
      v = 8'((k * 37 + 11) % 256);
      pulse(v);
      c0 += int'(v[2]);
      c2 += int'(v[7]);
    end
    rd(5'd0, d); chk("R5 counter0 sel2", d, 32'(c0));
    rd(5'd1, d); chk("R6 counter1 disabled", d, 0);
    rd(5'd2, d); chk("R5 counter2 sel7", d, 32'(c2));
    rd(5'd3, d); chk("R5 counter3 sel9", d, 0);
    wr(A_MODE, 32'h0);
    repeat (5) pulse(8'hFF);
    rd(5'd0, d); chk("R6 global off c0", d, 32'(c0));
    rd(5'd2, d); chk("R6 global off c2", d, 32'(c2));

    // R10 type readback
    wr(A_TYPE0 + 5'd1, 32'hFFFF_3F05);
    rd(A_TYPE0 + 5'd1, d); chk("R10 general type", d, 32'h0000_3F05);
    wr(A_TYPE0 + 5'd1, 32'h0000_0A05);
    rd(A_TYPE0 + 5'd1, d); chk("R10 filter update", d, 32'h0000_0A05);
    wr(A_TYPE_CYC, 32'h0000_2A05);
    rd(A_TYPE_CYC, d); chk("R10 cycle type", d, 32'h0000_2A11);

    // R7 R8 R11 overflow and loads, all selectors 0, filter 0, el 0
    do_reset();
    el = 2'd0; secure = 1'b0;
    wr(A_MODE, 32'h1);
    wr(A_EN, 32'h2);
    wr(5'd1, 32'hFFFF_FFFF);
    pulse(8'h01);
    rd(5'd1, d);  chk("R7 general wrap value", d, 0);
    rd(A_OVF, d); chk("R7 general wrap flag", d, 32'h2);
    wr(A_OVF, 32'h2);
    rd(A_OVF, d); chk("R8 clear", d, 0);
    wr(5'd1, 32'hFFFF_FFFF);
    evt_in = 8'h01;
    wr(A_OVF, 32'h2);
    evt_in = 8'h00;
    rd(A_OVF, d); chk("R8 set beats clear", d, 32'h2);
    wr(A_OVF, 32'h1);
    rd(A_OVF, d); chk("R8 zero bits kept", d, 32'h2);
    wr(A_OVF, 32'h2);
    rd(A_OVF, d); chk("R8 clear again", d, 0);
    evt_in = 8'h01;
    wr(5'd1, 32'd100);
    evt_in = 8'h00;
    rd(5'd1, d); chk("R11 load beats increment", d, 32'd100);
    rd(A_EN, d); chk("R13 enable pad", d, 32'h2);

    // R7 cycle counter wrap
    wr(A_CYC_LO, 32'hFFFF_FFFE);
    wr(A_CYC_HI, 32'hFFFF_FFFF);
    wr(A_EN, 32'h10);
    repeat (1) @(posedge clk);
    #1 wr(A_EN, 32'h0);
    rd(A_CYC_LO, d); chk("R7 cycle wrap low", d, 0);
    rd(A_CYC_HI, d); chk("R7 cycle wrap high", d, 0);
    rd(A_OVF, d);    chk("R7 cycle wrap flag", d, 32'h10);

    // R9 divider and filtered cycles
    do_reset();
    el = 2'd0; secure = 1'b1;
    wr(A_MODE, 32'h3);
    wr(A_EN, 32'h10);
    repeat (129) @(posedge clk);
    #1 wr(A_EN, 32'h0);
    rd(A_CYC_LO, d); chk("R9 div 130 cycles", d, 32'd2);
    el = 2'd1;
    wr(A_TYPE_CYC, 32'h100);
    wr(A_EN, 32'h10);
    repeat (199) @(posedge clk);
    #1 wr(A_EN, 32'h0);
    rd(A_CYC_LO, d); chk("R9 filtered not accumulated", d, 32'd2);
    el = 2'd0;
    wr(A_EN, 32'h10);
    repeat (61) @(posedge clk);
    #1 wr(A_EN, 32'h0);
    rd(A_CYC_LO, d); chk("R9 remainder carry", d, 32'd3);
    wr(A_MODE, 32'h1);
    wr(A_EN, 32'h10);
    repeat (9) @(posedge clk);
    #1 wr(A_EN, 32'h0);
    rd(A_CYC_LO, d); chk("R9 undivided", d, 32'd13);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule